// File: doc/BRIEF.md
# Dual-Stream Byte Interleaver and Splitter

A block twice the cache line in size is compressed as two independent halves. That gives two byte streams of different lengths. This block packs the pair into one byte-wide transfer stream and also takes that stream apart again. The packer is told both lengths, then emits a two-byte header and after it the bytes of the two halves. The bytes alternate between the halves until the shorter one runs out. After that, the rest of the longer one follows back to back.

The splitter reads the header and routes each data byte, in the cycle it arrives, to the output of lane A or lane B. Two decompressors can therefore begin work on the leading bytes before the transfer ends. Every edge uses a byte-wide valid/ready handshake. When both lanes have received all their bytes, the splitter pulses a completion flag. It is then ready for the next header.

Top module: `lane_interleave`

## Requirements
- R1: The first two bytes the packer emits after a start are the length of lane A and then the length of lane B, each as an unsigned byte value.
- R2: While both lanes still hold bytes, the packer takes data bytes alternately, and lane A comes first.
- R3: When one lane is exhausted, the packer takes every remaining byte of the other lane consecutively, with no byte from the empty lane.
- R4: The packer accepts a start only while `pack_busy` is low. `pack_busy` is high from the cycle after the start until the last data byte has been handed over. Each lane length must lie between 1 and LINE_BYTES.
- R5: The packer presents no output valid when idle, and it asserts no lane-input ready while it sends the header.
- R6: The splitter consumes the first two bytes of each transfer as the lane A and lane B lengths. It accepts them unconditionally (`unpk_s_ready` high) and forwards neither to a lane output.
- R7: The splitter routes data bytes by the same rule as the packer: alternate starting with A while both lanes have bytes left, then the remainder to the lane that still has bytes.
- R8: A data byte appears on its lane output in the same cycle it is presented on the input, with the input byte value unchanged.
- R9: The input ready of the splitter equals the ready of the lane output that the current data byte is routed to. A stalled lane holds back the whole input.
- R10: `unpk_done` is high for exactly one cycle, the cycle after the last data byte is accepted. The splitter then expects a new header.
- R11: After reset, `pack_busy`, `pack_m_valid`, both lane output valids and `unpk_done` are low, and `unpk_s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pack_start | input | 1 | Begin a packed transfer with the given lengths |
| pack_len_a | input | 8 | Byte count of lane A |
| pack_len_b | input | 8 | Byte count of lane B |
| pack_busy | output | 1 | Packer is running a transfer |
| pack_a_valid | input | 1 | Lane A byte available |
| pack_a_data | input | 8 | Lane A byte |
| pack_a_ready | output | 1 | Packer takes lane A byte |
| pack_b_valid | input | 1 | Lane B byte available |
| pack_b_data | input | 8 | Lane B byte |
| pack_b_ready | output | 1 | Packer takes lane B byte |
| pack_m_valid | output | 1 | Merged byte available |
| pack_m_data | output | 8 | Merged byte (header or data) |
| pack_m_ready | input | 1 | Downstream takes merged byte |
| unpk_s_valid | input | 1 | Incoming merged byte available |
| unpk_s_data | input | 8 | Incoming merged byte |
| unpk_s_ready | output | 1 | Splitter takes incoming byte |
| unpk_a_valid | output | 1 | Lane A output byte available |
| unpk_a_data | output | 8 | Lane A output byte |
| unpk_a_ready | input | 1 | Lane A consumer ready |
| unpk_b_valid | output | 1 | Lane B output byte available |
| unpk_b_data | output | 8 | Lane B output byte |
| unpk_b_ready | input | 1 | Lane B consumer ready |
| unpk_done | output | 1 | One-cycle pulse after the final data byte |

## Verification
The embedded properties check on every cycle the following:
- the packer never takes two bytes in a row from lane A while lane B still has bytes, and the reverse holds too;
- no lane is taken while the header is being sent, or after that lane is empty;
- the splitter never drives both lane valids at once, and never drives a lane valid without an input byte;
- a stall on the input can always be traced to a stalled lane;
- the completion flag never lasts two cycles.

Only the bench's sweeps can show the following:
- the exact byte order of every length pair;
- the header values;
- that each byte reaches the correct lane with its value intact;
- that busy and done fall in the right cycle under irregular back-pressure on every port.

// File: rtl/li_pkg.sv
package li_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        LANE_A = 1'b0,
        LANE_B = 1'b1
    } lane_e;

    typedef enum logic [1:0] {
        PK_IDLE,
        PK_HDR_A,
        PK_HDR_B,
        PK_DATA
    } pk_state_e;

    typedef enum logic [1:0] {
        UP_HDR_A,
        UP_HDR_B,
        UP_DATA
    } up_state_e;

    typedef struct packed {
        byte_t a;
        byte_t b;
    } len_pair_t;

    // While both lanes hold bytes the turn decides; otherwise the non-empty lane.
    function automatic lane_e pick_lane(input logic a_left, input logic b_left,
                                        input lane_e turn);
        if (a_left && b_left) return turn;
        if (a_left)           return LANE_A;
        return LANE_B;
    endfunction

    function automatic lane_e other_lane(input lane_e l);
        return (l == LANE_A) ? LANE_B : LANE_A;
    endfunction

endpackage

// File: rtl/li_tracker.sv
module li_tracker
    import li_pkg::*;
#(
    parameter int LINE_BYTES = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ld_a,
    input  logic      ld_b,
    input  len_pair_t len_in,
    input  logic      step,
    output len_pair_t cnt,
    output lane_e     sel,
    output logic      last
);

    lane_e turn;
    logic  empty;

    assign sel   = pick_lane(cnt.a != '0, cnt.b != '0, turn);
    assign last  = ({1'b0, cnt.a} + {1'b0, cnt.b}) == (BYTE_W + 1)'(1);
    assign empty = (cnt.a == '0) && (cnt.b == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            turn <= LANE_A;
        end else begin
            if (ld_a) begin
                cnt.a <= len_in.a;
                turn  <= LANE_A;
            end
            if (ld_b) begin
                cnt.b <= len_in.b;
            end
            if (step) begin
                if (sel == LANE_A) cnt.a <= cnt.a - 1'b1;
                else               cnt.b <= cnt.b - 1'b1;
                turn <= other_lane(sel);
            end
        end
    end

    // R7: a byte is only ever taken while some lane still owes bytes
    p_step_legal_r7: assert property (@(posedge clk) disable iff (rst)
        step |-> !empty);

    // R4: remaining counts never exceed the line size
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (32'(cnt.a) <= LINE_BYTES) && (32'(cnt.b) <= LINE_BYTES));

endmodule

// File: rtl/li_packer.sv
module li_packer
    import li_pkg::*;
#(
    parameter int LINE_BYTES = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  byte_t len_a,
    input  byte_t len_b,
    output logic  busy,
    input  logic  a_valid,
    input  byte_t a_data,
    output logic  a_ready,
    input  logic  b_valid,
    input  byte_t b_data,
    output logic  b_ready,
    output logic  m_valid,
    output byte_t m_data,
    input  logic  m_ready
);

    pk_state_e state, state_n;
    len_pair_t cnt;
    lane_e     sel;
    logic      last, load, step;

    assign load = (state == PK_IDLE) && start;
    assign busy = (state != PK_IDLE);

    always_comb begin
        m_valid = 1'b0;
        m_data  = '0;
        a_ready = 1'b0;
        b_ready = 1'b0;
        unique case (state)
            PK_HDR_A: begin m_valid = 1'b1; m_data = cnt.a; end
            PK_HDR_B: begin m_valid = 1'b1; m_data = cnt.b; end
            PK_DATA: begin
                if (sel == LANE_A) begin
                    m_valid = a_valid;
                    m_data  = a_data;
                    a_ready = m_ready;
                end else begin
                    m_valid = b_valid;
                    m_data  = b_data;
                    b_ready = m_ready;
                end
            end
            default: ;
        endcase
    end

    assign step = (state == PK_DATA) && m_valid && m_ready;

    always_comb begin
        state_n = state;
        unique case (state)
            PK_IDLE:  if (start)   state_n = PK_HDR_A;
            PK_HDR_A: if (m_ready) state_n = PK_HDR_B;
            PK_HDR_B: if (m_ready) state_n = PK_DATA;
            PK_DATA:  if (step && last) state_n = PK_IDLE;
            default:  state_n = PK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PK_IDLE;
        else     state <= state_n;
    end

    li_tracker #(.LINE_BYTES(LINE_BYTES)) u_trk (
        .clk    (clk),
        .rst    (rst),
        .ld_a   (load),
        .ld_b   (load),
        .len_in ('{a: len_a, b: len_b}),
        .step   (step),
        .cnt    (cnt),
        .sel    (sel),
        .last   (last)
    );

    // R2: after lane A is taken and B still owes bytes, A is not taken next cycle
    p_alt_a_r2: assert property (@(posedge clk) disable iff (rst)
        (a_valid && a_ready && cnt.b != '0) |=> !a_ready);
    p_alt_b_r2: assert property (@(posedge clk) disable iff (rst)
        (b_valid && b_ready && cnt.a != '0) |=> !b_ready);

    // R3: an exhausted lane is never taken again
    p_tail_a_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt.a == '0) |-> !a_ready);
    p_tail_b_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt.b == '0) |-> !b_ready);

    // R5: no lane input is taken during the header or while idle
    p_hdr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state != PK_DATA) |-> (!a_ready && !b_ready));

    // R5: idle packer presents nothing
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !m_valid);

endmodule

// File: rtl/li_unpacker.sv
module li_unpacker
    import li_pkg::*;
#(
    parameter int LINE_BYTES = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  s_valid,
    input  byte_t s_data,
    output logic  s_ready,
    output logic  oa_valid,
    output byte_t oa_data,
    input  logic  oa_ready,
    output logic  ob_valid,
    output byte_t ob_data,
    input  logic  ob_ready,
    output logic  done
);

    up_state_e state, state_n;
    len_pair_t cnt;
    lane_e     sel;
    logic      last, ld_a, ld_b, step;

    assign ld_a = (state == UP_HDR_A) && s_valid;
    assign ld_b = (state == UP_HDR_B) && s_valid;

    assign oa_data  = s_data;
    assign ob_data  = s_data;
    assign oa_valid = (state == UP_DATA) && (sel == LANE_A) && s_valid;
    assign ob_valid = (state == UP_DATA) && (sel == LANE_B) && s_valid;

    always_comb begin
        if (state == UP_DATA) s_ready = (sel == LANE_A) ? oa_ready : ob_ready;
        else                  s_ready = 1'b1;
    end

    assign step = (state == UP_DATA) && s_valid && s_ready;

    always_comb begin
        state_n = state;
        unique case (state)
            UP_HDR_A: if (s_valid) state_n = UP_HDR_B;
            UP_HDR_B: if (s_valid) state_n = UP_DATA;
            UP_DATA:  if (step && last) state_n = UP_HDR_A;
            default:  state_n = UP_HDR_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= UP_HDR_A;
            done  <= 1'b0;
        end else begin
            state <= state_n;
            done  <= step && last;
        end
    end

    li_tracker #(.LINE_BYTES(LINE_BYTES)) u_trk (
        .clk    (clk),
        .rst    (rst),
        .ld_a   (ld_a),
        .ld_b   (ld_b),
        .len_in ('{a: s_data, b: s_data}),
        .step   (step),
        .cnt    (cnt),
        .sel    (sel),
        .last   (last)
    );

    // R7: a byte goes to at most one lane, and never to an exhausted one
    p_route_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(oa_valid && ob_valid));
    p_route_tail_r7: assert property (@(posedge clk) disable iff (rst)
        ((cnt.a == '0) |-> !oa_valid) and ((cnt.b == '0) |-> !ob_valid));

    // R8: lane outputs only ever carry a byte that is present on the input
    p_no_wait_r8: assert property (@(posedge clk) disable iff (rst)
        (oa_valid || ob_valid) |-> s_valid);

    // R6: header bytes never leak onto a lane
    p_hdr_swallow_r6: assert property (@(posedge clk) disable iff (rst)
        (state != UP_DATA) |-> (!oa_valid && !ob_valid && s_ready));

    // R9: an input stall is always caused by the addressed lane stalling
    p_stall_cause_r9: assert property (@(posedge clk) disable iff (rst)
        (s_valid && !s_ready) |-> ((oa_valid && !oa_ready) || (ob_valid && !ob_ready)));

    // R10: completion lasts a single cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/lane_interleave.sv
module lane_interleave
    import li_pkg::*;
#(
    parameter int LINE_BYTES = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pack_start,
    input  logic [7:0] pack_len_a,
    input  logic [7:0] pack_len_b,
    output logic       pack_busy,
    input  logic       pack_a_valid,
    input  logic [7:0] pack_a_data,
    output logic       pack_a_ready,
    input  logic       pack_b_valid,
    input  logic [7:0] pack_b_data,
    output logic       pack_b_ready,
    output logic       pack_m_valid,
    output logic [7:0] pack_m_data,
    input  logic       pack_m_ready,
    input  logic       unpk_s_valid,
    input  logic [7:0] unpk_s_data,
    output logic       unpk_s_ready,
    output logic       unpk_a_valid,
    output logic [7:0] unpk_a_data,
    input  logic       unpk_a_ready,
    output logic       unpk_b_valid,
    output logic [7:0] unpk_b_data,
    input  logic       unpk_b_ready,
    output logic       unpk_done
);

    li_packer #(.LINE_BYTES(LINE_BYTES)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .start   (pack_start),
        .len_a   (pack_len_a),
        .len_b   (pack_len_b),
        .busy    (pack_busy),
        .a_valid (pack_a_valid),
        .a_data  (pack_a_data),
        .a_ready (pack_a_ready),
        .b_valid (pack_b_valid),
        .b_data  (pack_b_data),
        .b_ready (pack_b_ready),
        .m_valid (pack_m_valid),
        .m_data  (pack_m_data),
        .m_ready (pack_m_ready)
    );

    li_unpacker #(.LINE_BYTES(LINE_BYTES)) u_unpk (
        .clk      (clk),
        .rst      (rst),
        .s_valid  (unpk_s_valid),
        .s_data   (unpk_s_data),
        .s_ready  (unpk_s_ready),
        .oa_valid (unpk_a_valid),
        .oa_data  (unpk_a_data),
        .oa_ready (unpk_a_ready),
        .ob_valid (unpk_b_valid),
        .ob_data  (unpk_b_data),
        .ob_ready (unpk_b_ready),
        .done     (unpk_done)
    );

endmodule

// File: tb/lane_interleave_test.sv
module lane_interleave_test;

    localparam int LB = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       pack_start;
    logic [7:0] pack_len_a, pack_len_b;
    logic       pack_busy;
    logic       pack_a_valid, pack_a_ready, pack_b_valid, pack_b_ready;
    logic [7:0] pack_a_data, pack_b_data;
    logic       pack_m_valid, pack_m_ready;
    logic [7:0] pack_m_data;
    logic       unpk_s_valid, unpk_s_ready;
    logic [7:0] unpk_s_data;
    logic       unpk_a_valid, unpk_a_ready, unpk_b_valid, unpk_b_ready;
    logic [7:0] unpk_a_data, unpk_b_data;
    logic       unpk_done;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lane_interleave #(.LINE_BYTES(LB)) uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int a_byte(input int k); return 8'h40 + k; endfunction
    function automatic int b_byte(input int k); return 8'h80 + k; endfunction

    // lane of data byte j: 0 = A, 1 = B
    function automatic int exp_lane(input int la, input int lb, input int j);
        int m = (la < lb) ? la : lb;
        if (j < 2 * m) return j % 2;
        return (la > lb) ? 0 : 1;
    endfunction

    // position of data byte j within its own lane
    function automatic int exp_pos(input int la, input int lb, input int j);
        int m = (la < lb) ? la : lb;
        if (j < 2 * m) return j / 2;
        return m + (j - 2 * m);
    endfunction

    function automatic int exp_merged(input int la, input int lb, input int idx);
        int j;
        if (idx == 0) return la;
        if (idx == 1) return lb;
        j = idx - 2;
        if (exp_lane(la, lb, j) == 0) return a_byte(exp_pos(la, lb, j));
        return b_byte(exp_pos(la, lb, j));
    endfunction

    task automatic run_pack(input int la, input int lb, input int v);
        int ia = 0, ib = 0, oidx = 0, guard = 0;
        int total = la + lb + 2;
        bit ha, hb, hm;
        @(negedge clk);
        pack_start = 1'b1; pack_len_a = 8'(la); pack_len_b = 8'(lb);
        #1 chk(pack_busy == 1'b0, "R4 idle before start", pack_busy, 0);
        @(posedge clk);
        @(negedge clk);
        pack_start = 1'b0;
        while (oidx < total && guard < 200) begin
            if (guard > 0) @(negedge clk);
            guard++;
            pack_m_ready = (v == 0) || (cyc % 3 != 1);
            pack_a_valid = (ia < la) && ((v == 0) || (cyc % 4 != 2));
            pack_a_data  = 8'(a_byte(ia));
            pack_b_valid = (ib < lb) && ((v == 0) || (cyc % 5 != 3));
            pack_b_data  = 8'(b_byte(ib));
            #1;
            chk(pack_busy == 1'b1, "R4 busy during transfer", pack_busy, 1);
            if (oidx < 2)
                chk(!pack_a_ready && !pack_b_ready, "R5 no lane taken in header",
                    {pack_a_ready, pack_b_ready}, 0);
            ha = pack_a_valid && pack_a_ready;
            hb = pack_b_valid && pack_b_ready;
            hm = pack_m_valid && pack_m_ready;
            if (hm)
                chk(pack_m_data == 8'(exp_merged(la, lb, oidx)),
                    (oidx < 2) ? "R1 header byte" : "R2/R3 merged order R2 R3",
                    pack_m_data, exp_merged(la, lb, oidx));
            @(posedge clk);
            if (ha) ia++;
            if (hb) ib++;
            if (hm) oidx++;
        end
        chk(oidx == total, "R3 all bytes emitted", oidx, total);
        chk(ia == la && ib == lb, "R3 all lane bytes taken", ia * 16 + ib, la * 16 + lb);
        @(negedge clk);
        pack_a_valid = 1'b0; pack_b_valid = 1'b0;
        #1;
        chk(pack_busy == 1'b0, "R4 busy drops after last byte", pack_busy, 0);
        chk(pack_m_valid == 1'b0, "R5 idle output quiet", pack_m_valid, 0);
    endtask

    task automatic run_unpk(input int la, input int lb, input int v);
        int iidx = 0, ka = 0, kb = 0, guard = 0, lane;
        int total = la + lb + 2;
        bit hs, hoa, hob;
        while (iidx < total && guard < 200) begin
            @(negedge clk);
            guard++;
            unpk_s_valid = (v == 0) || (cyc % 4 != 1);
            unpk_s_data  = 8'(exp_merged(la, lb, iidx));
            unpk_a_ready = (v == 0) || (cyc % 3 != 2);
            unpk_b_ready = (v == 0) || (cyc % 2 == 0);
            #1;
            chk(unpk_done == 1'b0, "R10 no early done", unpk_done, 0);
            if (iidx < 2) begin
                chk(!unpk_a_valid && !unpk_b_valid && unpk_s_ready,
                    "R6 header swallowed", {unpk_a_valid, unpk_b_valid, unpk_s_ready}, 1);
            end else if (unpk_s_valid) begin
                lane = exp_lane(la, lb, iidx - 2);
                chk(unpk_a_valid == (lane == 0) && unpk_b_valid == (lane == 1),
                    "R7 R8 lane routing", {unpk_a_valid, unpk_b_valid}, (lane == 0) ? 2 : 1);
                chk(unpk_s_ready == ((lane == 0) ? unpk_a_ready : unpk_b_ready),
                    "R9 back-pressure", unpk_s_ready, (lane == 0) ? unpk_a_ready : unpk_b_ready);
            end
            hs  = unpk_s_valid && unpk_s_ready;
            hoa = unpk_a_valid && unpk_a_ready;
            hob = unpk_b_valid && unpk_b_ready;
            if (hoa) chk(unpk_a_data == 8'(a_byte(ka)), "R8 lane A value", unpk_a_data, a_byte(ka));
            if (hob) chk(unpk_b_data == 8'(b_byte(kb)), "R8 lane B value", unpk_b_data, b_byte(kb));
            @(posedge clk);
            if (hs)  iidx++;
            if (hoa) ka++;
            if (hob) kb++;
        end
        chk(ka == la && kb == lb, "R7 lane byte counts", ka * 16 + kb, la * 16 + lb);
        @(negedge clk);
        unpk_s_valid = 1'b0;
        #1 chk(unpk_done == 1'b1, "R10 done pulse", unpk_done, 1);
        @(negedge clk);
        #1 chk(unpk_done == 1'b0, "R10 done single cycle", unpk_done, 0);
        chk(unpk_s_ready == 1'b1, "R10 ready for next header", unpk_s_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        pack_start = 1'b0; pack_len_a = '0; pack_len_b = '0;
        pack_a_valid = 1'b0; pack_a_data = '0;
        pack_b_valid = 1'b0; pack_b_data = '0;
        pack_m_ready = 1'b1;
        unpk_s_valid = 1'b0; unpk_s_data = '0;
        unpk_a_ready = 1'b1; unpk_b_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!pack_busy && !pack_m_valid, "R11 packer reset", {pack_busy, pack_m_valid}, 0);
        chk(!unpk_a_valid && !unpk_b_valid && !unpk_done, "R11 splitter reset",
            {unpk_a_valid, unpk_b_valid, unpk_done}, 0);
        chk(unpk_s_ready == 1'b1, "R11 splitter ready", unpk_s_ready, 1);

        for (int v = 0; v < 2; v++)
            for (int la = 1; la <= LB; la++)
                for (int lb = 1; lb <= LB; lb++) begin
                    run_pack(la, lb, v);
                    run_unpk(la, lb, v);
                end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule